// File: doc/BRIEF.md
# Master/Slave Synchronous Serial Shift Port

This block is an eight-bit synchronous serial port that acts either as the clock master or as a clocked slave. A single mode input chooses the role. As master, the block divides the core clock down to a shift clock. A four-bit selector picks one of fourteen power-of-two rates. As slave, the block takes the shift clock from an input pin. That pin passes through a two-flop synchronizer and an edge detector before the block uses it.

The host writes a byte into the data register, which starts a transfer. It can read the register back at any time. The block drives outgoing bits MSB first and advances them on each falling shift-clock edge. It samples incoming bits on each rising edge. After eight bits the register holds the received byte. The busy flag then drops, a sticky done flag rises, and a one-cycle interrupt pulse is emitted.

Top module: `sio_port`

## Requirements
- R1: While rst_ni is low, rd_data_o is 0 and busy_o, done_o, irq_o and sck_o are all 0.
- R2: With master_i high the shift clock comes from the internal divider and appears on sck_o. With master_i low the shift clock comes from sck_i, and sck_o stays 0.
- R3: A write pulse (wr_en_i high for one clock) while the port is idle loads wr_data_i into the data register. The same write sets busy_o and clears done_o. A write while busy_o is high is ignored. rd_data_o always shows the data register.
- R4: Bits leave on sdo_o MSB first. sdo_o shows bit 7 of the loaded byte right after the load and changes only after a falling shift-clock edge.
- R5: sdi_i is sampled on each rising shift-clock edge. After eight bits rd_data_o holds the eight sampled bits, the first sampled bit in bit 7.
- R6: In master mode each half period of sck_o lasts 8·2^s core cycles, where s is rate_sel_i. Values of rate_sel_i from 0 to 13 are used directly, and values above 13 act as 13. Measured from the load edge, the first rising edge of sck_o comes after one half period.
- R7: In master mode sck_o is low whenever no transfer is active.
- R8: The eighth falling shift-clock edge clears busy_o and sets done_o in the same cycle, and irq_o is high for exactly that one cycle.
- R9: In slave mode, edges on sck_i while the port is idle change neither the data register nor any status output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_i | input | 1 | 1 = master (internal clock), 0 = slave (external clock) |
| rate_sel_i | input | 4 | Master rate step; half period is 8·2^s core cycles, s capped at 13 |
| wr_en_i | input | 1 | Host write strobe for the data register |
| wr_data_i | input | 8 | Host write data |
| rd_data_o | output | 8 | Data register contents |
| sck_i | input | 1 | External shift clock (slave mode) |
| sck_o | output | 1 | Generated shift clock (master mode) |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | Sticky transfer-complete flag, cleared by the next accepted write |
| irq_o | output | 1 | One-cycle pulse at transfer completion |

## Verification
The assertions assume that master_i and rate_sel_i stay unchanged while busy_o is high. A mode or rate change during a transfer would leave the divider counter above its new limit, or would mix the two clock sources mid-byte. The bench therefore sets the mode and rate before each write and changes them only once busy_o has fallen. In slave mode it holds each sck_i level and each sdi_i bit for at least five core cycles, so that the synchronizer delay never merges edges or samples data out of step with the clock.

// File: rtl/sio_pkg.sv
package sio_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } sck_evt_t;
endpackage

// File: rtl/sio_clkgen.sv
module sio_clkgen import sio_pkg::*; #(
  parameter int unsigned NUM_RATES     = 14,
  parameter int unsigned MIN_HALF_LOG2 = 3,
  parameter int unsigned SEL_W         = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [SEL_W-1:0] rate_sel_i,
  output logic             sck_o,
  output sck_evt_t         evt_o
);
  localparam int unsigned MAX_SEL = NUM_RATES - 1;
  localparam int unsigned CNT_W   = MIN_HALF_LOG2 + NUM_RATES - 1;

  logic [SEL_W-1:0] sel_c;
  logic [CNT_W-1:0] half_m1, cnt_q;
  logic             sck_q, tick;

  assign sel_c   = (rate_sel_i > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : rate_sel_i;
  assign half_m1 = (CNT_W'(1) << (CNT_W'(sel_c) + CNT_W'(MIN_HALF_LOG2))) - CNT_W'(1);
  assign tick    = en_i && (cnt_q >= half_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (!en_i) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign sck_o      = sck_q;
  assign evt_o.rise = tick & ~sck_q;
  assign evt_o.fall = tick & sck_q;

  // R6
  half_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= half_m1);
  // R7
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !sck_q);
endmodule

// File: rtl/sio_sync_edge.sv
module sio_sync_edge import sio_pkg::*; #(
  parameter int unsigned STAGES = 2
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     sck_i,
  input  logic     sdi_i,
  output sck_evt_t evt_o,
  output logic     sdi_o
);
  logic [STAGES-1:0] sck_sync, sdi_sync;
  logic              sck_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_sync <= '0;
      sdi_sync <= '0;
      sck_last <= 1'b0;
    end else begin
      sck_sync <= {sck_sync[STAGES-2:0], sck_i};
      sdi_sync <= {sdi_sync[STAGES-2:0], sdi_i};
      sck_last <= sck_sync[STAGES-1];
    end
  end

  assign evt_o.rise = sck_sync[STAGES-1] & ~sck_last;
  assign evt_o.fall = ~sck_sync[STAGES-1] & sck_last;
  assign sdi_o      = sdi_sync[STAGES-1];

  // R9
  edge_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o.rise |=> !evt_o.rise);
endmodule

// File: rtl/sio_shifter.sv
module sio_shifter import sio_pkg::*; #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  sck_evt_t          evt_i,
  input  logic              sdi_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sdo_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              irq_o
);
  localparam int unsigned BIT_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sr_q;
  logic [BIT_W-1:0]  bit_q;
  logic              cap_q, busy_q, done_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      bit_q  <= '0;
      cap_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (wr_i && !busy_q) begin
        sr_q   <= wr_data_i;
        bit_q  <= '0;
        busy_q <= 1'b1;
        done_q <= 1'b0;
      end else if (busy_q) begin
        if (evt_i.rise) cap_q <= sdi_i;
        if (evt_i.fall) begin
          sr_q  <= {sr_q[DATA_W-2:0], cap_q};
          bit_q <= bit_q + BIT_W'(1);
          if (bit_q == BIT_W'(DATA_W - 1)) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
            irq_q  <= 1'b1;
          end
        end
      end
    end
  end

  assign data_o = sr_q;
  assign sdo_o  = sr_q[DATA_W-1];
  assign busy_o = busy_q;
  assign done_o = done_q;
  assign irq_o  = irq_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> (!busy_q && done_q));
  // R8
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q);
  // R4
  shift_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !evt_i.fall) |=> $stable(sr_q));
  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_q && !wr_i) |=> ($stable(sr_q) && !irq_q));
endmodule

// File: rtl/sio_port.sv
module sio_port import sio_pkg::*; #(
  parameter int unsigned DATA_W        = 8,
  parameter int unsigned NUM_RATES     = 14,
  parameter int unsigned MIN_HALF_LOG2 = 3,
  parameter int unsigned SEL_W         = 4,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              master_i,
  input  logic [SEL_W-1:0]  rate_sel_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              sck_i,
  output logic              sck_o,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              irq_o
);
  sck_evt_t gen_evt, ext_evt, evt_sel;
  logic     ext_sdi, sdi_sel, gen_en;

  assign gen_en = busy_o & master_i;

  sio_clkgen #(
    .NUM_RATES(NUM_RATES), .MIN_HALF_LOG2(MIN_HALF_LOG2), .SEL_W(SEL_W)
  ) u_clkgen (
    .clk_i, .rst_ni, .en_i(gen_en), .rate_sel_i, .sck_o, .evt_o(gen_evt)
  );

  sio_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sck_i, .sdi_i, .evt_o(ext_evt), .sdi_o(ext_sdi)
  );

  // master samples the pin directly; slave uses the synced copy aligned to the synced clock
  assign evt_sel = master_i ? gen_evt : ext_evt;
  assign sdi_sel = master_i ? sdi_i : ext_sdi;

  sio_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni, .wr_i(wr_en_i), .wr_data_i, .evt_i(evt_sel), .sdi_i(sdi_sel),
    .data_o(rd_data_o), .sdo_o, .busy_o, .done_o, .irq_o
  );

  // R2
  mode_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> ($stable(master_i) && $stable(rate_sel_i)));
  // R2
  slave_sck_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !master_i |-> !sck_o);
endmodule

// File: tb/sio_port_bench.sv
module sio_port_bench;
  logic       clk_i = 1'b0, rst_ni = 1'b0, master_i = 1'b1, wr_en_i = 1'b0;
  logic       sck_i = 1'b0, sdi_i = 1'b0;
  logic [3:0] rate_sel_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [7:0] rd_data_o;
  logic       sck_o, sdo_o, busy_o, done_o, irq_o;

  int n_chk = 0, n_fail = 0, irq_seen = 0;
  bit slave_sck_bad = 1'b0, ended = 1'b0;

  always #4 clk_i = ~clk_i;

  sio_port u_sio_port (.*);

  always @(negedge clk_i) begin
    if (irq_o) irq_seen++;
    if (!master_i && sck_o) slave_sck_bad = 1'b1;
  end

  function automatic int exp_half(int sel);
    int s = (sel > 13) ? 13 : sel;
    return 8 << s;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic host_write(logic [7:0] d);
    @(negedge clk_i); wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk_i); wr_en_i = 1'b0;
  endtask

  task automatic master_xfer(int sel, logic [7:0] tx, logic [7:0] rx, bit inject);
    int n, irq0;
    logic [7:0] got;
    bit idle_bad = 1'b0;
    master_i = 1'b1; rate_sel_i = sel[3:0]; sdi_i = rx[7];
    @(negedge clk_i); irq0 = irq_seen;
    host_write(tx);
    chk(busy_o == 1'b1, "R3 busy after write", busy_o, 1);
    chk(done_o == 1'b0, "R3 done cleared by write", done_o, 0);
    chk(sdo_o == tx[7], "R4 msb out after load", sdo_o, tx[7]);
    n = 0;
    while (!sck_o) begin @(negedge clk_i); n++; end
    chk(n == exp_half(sel), "R6 first half period", n, exp_half(sel));
    for (int k = 7; k >= 0; k--) begin
      got[k] = sdo_o;
      while (sck_o) @(negedge clk_i);
      if (k > 0) sdi_i = rx[k-1];
      if (inject && k == 4) host_write(~tx);
      if (k > 0) while (!sck_o) @(negedge clk_i);
    end
    chk(busy_o == 1'b0, "R8 busy clears on last fall", busy_o, 0);
    chk(done_o == 1'b1, "R8 done set", done_o, 1);
    chk(irq_o == 1'b1, "R8 irq pulse", irq_o, 1);
    chk(rd_data_o == rx, "R5 received byte", rd_data_o, rx);
    chk(got == tx, inject ? "R3 write during busy ignored" : "R4 msb-first out", got, tx);
    @(negedge clk_i);
    chk(irq_o == 1'b0, "R8 irq one cycle", irq_o, 0);
    repeat (3 * exp_half(sel)) begin
      @(negedge clk_i);
      if (sck_o) idle_bad = 1'b1;
    end
    chk(!idle_bad, "R7 sck idles low", idle_bad, 0);
    chk(irq_seen - irq0 == 1, "R8 single irq", irq_seen - irq0, 1);
  endtask

  task automatic slave_xfer(logic [7:0] tx, logic [7:0] rx, int hp);
    int irq0;
    logic [7:0] got;
    master_i = 1'b0; sck_i = 1'b0;
    @(negedge clk_i); irq0 = irq_seen;
    host_write(tx);
    chk(busy_o == 1'b1, "R3 busy after write (slave)", busy_o, 1);
    for (int k = 7; k >= 0; k--) begin
      sdi_i = rx[k];
      repeat (hp) @(negedge clk_i);
      sck_i = 1'b1; got[k] = sdo_o;
      repeat (hp) @(negedge clk_i);
      sck_i = 1'b0;
    end
    repeat (6) @(negedge clk_i);
    chk(busy_o == 1'b0, "R8 busy clears (slave)", busy_o, 0);
    chk(done_o == 1'b1, "R8 done set (slave)", done_o, 1);
    chk(rd_data_o == rx, "R5 received byte (slave)", rd_data_o, rx);
    chk(got == tx, "R4 msb-first out (slave)", got, tx);
    chk(irq_seen - irq0 == 1, "R8 single irq (slave)", irq_seen - irq0, 1);
    chk(!slave_sck_bad, "R2 sck_o low in slave mode", slave_sck_bad, 0);
  endtask

  task automatic finish_up();
    if (!ended) begin
      ended = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    finish_up();
  end

  initial begin
    int n, irq0;
    logic [7:0] keep;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk_i);
    // R1
    chk(rd_data_o == 8'h00 && !busy_o && !done_o && !irq_o && !sck_o,
        "R1 reset state", {rd_data_o, busy_o, done_o, irq_o, sck_o}, 0);
    rst_ni = 1'b1;

    master_xfer(0, 8'h00, 8'hFF, 1'b0);
    master_xfer(1, 8'hFF, 8'h00, 1'b0);
    master_xfer(2, 8'hC3, 8'h5A, 1'b1);
    for (int i = 0; i < 6; i++)
      master_xfer($urandom_range(0, 3), 8'($urandom), 8'($urandom), 1'b0);

    slave_xfer(8'hA5, 8'h3C, 5);
    for (int i = 0; i < 4; i++)
      slave_xfer(8'($urandom), 8'($urandom), $urandom_range(5, 9));

    // R9: idle edges on sck_i are ignored
    master_i = 1'b0; keep = rd_data_o; irq0 = irq_seen;
    for (int i = 0; i < 8; i++) begin
      sdi_i = ~sdi_i;
      repeat (5) @(negedge clk_i); sck_i = 1'b1;
      repeat (5) @(negedge clk_i); sck_i = 1'b0;
    end
    repeat (6) @(negedge clk_i);
    chk(rd_data_o == keep, "R9 idle edges keep data", rd_data_o, keep);
    chk(!busy_o && done_o && irq_seen == irq0, "R9 idle edges keep status",
        {busy_o, done_o}, 1);

    // R6: out-of-range step clamps to the slowest rate
    master_xfer(3, 8'h81, 8'h18, 1'b0);
    master_i = 1'b1; rate_sel_i = 4'd15;
    host_write(8'h42);
    n = 0;
    while (!sck_o) begin @(negedge clk_i); n++; end
    chk(n == exp_half(15), "R6 clamped half period", n, exp_half(15));
    rst_ni = 1'b0;
    @(negedge clk_i);
    chk(!busy_o && !sck_o && rd_data_o == 8'h00, "R1 reset mid-transfer",
        {busy_o, sck_o, rd_data_o}, 0);
    rst_ni = 1'b1;
    master_xfer(0, 8'h96, 8'h69, 1'b0);
    finish_up();
  end
endmodule